// File: doc/BRIEF.md
# Asynchronous memory strobe sequencer

This block drives the control strobes of an external asynchronous memory bus for one access at a time. A requester presents a read or write, the index of the target chip-select and the write data. The block then runs a counter in controller clock cycles. It pulls the selected chip-select, the address-valid strobe, the write-enable strobe and the output-enable strobe low inside windows that software programs as start and end cycle numbers.

Each strobe can be retimed half a clock later. A scale bit doubles every programmed cycle count. After each access the block stays idle for a programmable recovery time before it accepts the next request. That recovery is the larger of a turnaround time and a chip-select recovery time, and the chip-select recovery time counts only when its enable for the same or for a different chip-select matches the next request. Read data is captured at the programmed access point. A one-cycle done pulse closes every access.

Top module: `amem_strobe_seq`

## Requirements
- R1: After reset and whenever no access is running, every chip-select line and the address-valid, write-enable and output-enable strobes are high, `rsp_done` is low, and `req_ready` is high until the first access has been accepted.
- R2: Cycle 0 is the cycle after the clock edge that accepts the request. Only the chip-select line whose index equals the latched `req_cs` goes low. It is low in every cycle k with on ≤ k < off, where on is `t_cs_on` and off is `t_cs_rd_off` for a read or `t_cs_wr_off` for a write. All other chip-select lines stay high.
- R3: `mem_av_n` is low in every cycle k with `t_av_on` ≤ k < off, where off is `t_av_rd_off` for a read and `t_av_wr_off` for a write.
- R4: `mem_we_n` is low only during writes, for `t_we_on` ≤ k < `t_we_off`. `mem_oe_n` is low only during reads, for `t_oe_on` ≤ k < `t_oe_off`. The output-enable strobe is never low while `mem_dout_en` is high.
- R5: An access lasts T cycles, where T is the total read or write cycle time and a value of 0 is treated as 1. No window extends past cycle T-1. `rsp_done` is high for exactly one cycle, cycle T, and no strobe is low in its first half unless that strobe is half-cycle delayed.
- R6: A read captures `mem_din` at the clock edge that ends cycle `t_access` (with `t_access` < T). `rsp_rdata` shows the captured value from the done cycle until the next read captures. During a write, `mem_dout` holds the write data and `mem_dout_en` is high for cycles 0 to T-1 only.
- R7: When `late_cs`, `late_av`, `late_we` or `late_oe` is set, both edges of that strobe move half a clock later: each edge follows the falling clock edge in the middle of the cycle where the undelayed edge would occur.
- R8: With `scale_x2` set, every timing field (window points, access point, cycle times, turnaround and recovery) counts twice its programmed value.
- R9: Counting from the done cycle, `req_ready` stays low for exactly N cycles and is high in the next one. N is the largest of the timing values that apply. With only the turnaround applying, N = `t_turn`.
- R10: The time `t_recov` applies only when `recov_same_en` is set and the next `req_cs` equals the chip-select of the last access, or when `recov_diff_en` is set and the two differ.
- R11: When the turnaround and the recovery time both apply, N is the larger of the two, not their sum.
- R12: A request presented while `req_ready` is low is not taken: all strobes stay high and the block does not start until `req_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | Target chip-select index |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | DW | Last captured read data |
| t_cs_on | input | TW | Chip-select start cycle |
| t_cs_rd_off | input | TW | Chip-select end cycle for reads |
| t_cs_wr_off | input | TW | Chip-select end cycle for writes |
| t_av_on | input | TW | Address-valid start cycle |
| t_av_rd_off | input | TW | Address-valid end cycle for reads |
| t_av_wr_off | input | TW | Address-valid end cycle for writes |
| t_we_on | input | TW | Write-enable start cycle |
| t_we_off | input | TW | Write-enable end cycle |
| t_oe_on | input | TW | Output-enable start cycle |
| t_oe_off | input | TW | Output-enable end cycle |
| t_access | input | TW | Read capture cycle |
| t_rd_cycle | input | TW | Total read cycles |
| t_wr_cycle | input | TW | Total write cycles |
| t_turn | input | TW | Turnaround cycles between accesses |
| t_recov | input | TW | Chip-select recovery cycles |
| late_cs | input | 1 | Half-cycle delay for chip-select |
| late_av | input | 1 | Half-cycle delay for address-valid |
| late_we | input | 1 | Half-cycle delay for write-enable |
| late_oe | input | 1 | Half-cycle delay for output-enable |
| scale_x2 | input | 1 | Double all timing values |
| recov_same_en | input | 1 | Apply recovery for the same chip-select |
| recov_diff_en | input | 1 | Apply recovery for a different chip-select |
| mem_cs_n | output | NCS | Active-low chip-selects |
| mem_av_n | output | 1 | Active-low address-valid |
| mem_we_n | output | 1 | Active-low write-enable |
| mem_oe_n | output | 1 | Active-low output-enable |
| mem_dout | output | DW | Data driven to memory |
| mem_dout_en | output | 1 | Data output enable |
| mem_din | input | DW | Data from memory |

## Verification
The bench builds the block with four chip-selects, 5-bit timing fields and 16-bit data. With these values it can pick every chip-select index, so both the same-select and the different-select recovery cases can be reached. With doubling enabled, the scaled counts of up to 62 still fit the counter. The bench samples every strobe twice per cycle, once in each clock phase, so that half-cycle retiming can be seen. It also drives a read-data value that changes every cycle, so that a capture one cycle early or late shows up in the returned data.

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq #(
  parameter int NCS = 4,
  parameter int TW  = 5,
  parameter int DW  = 16,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int CW  = TW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_done,
  output logic [DW-1:0]  rsp_rdata,
  input  logic [TW-1:0]  t_cs_on,
  input  logic [TW-1:0]  t_cs_rd_off,
  input  logic [TW-1:0]  t_cs_wr_off,
  input  logic [TW-1:0]  t_av_on,
  input  logic [TW-1:0]  t_av_rd_off,
  input  logic [TW-1:0]  t_av_wr_off,
  input  logic [TW-1:0]  t_we_on,
  input  logic [TW-1:0]  t_we_off,
  input  logic [TW-1:0]  t_oe_on,
  input  logic [TW-1:0]  t_oe_off,
  input  logic [TW-1:0]  t_access,
  input  logic [TW-1:0]  t_rd_cycle,
  input  logic [TW-1:0]  t_wr_cycle,
  input  logic [TW-1:0]  t_turn,
  input  logic [TW-1:0]  t_recov,
  input  logic           late_cs,
  input  logic           late_av,
  input  logic           late_we,
  input  logic           late_oe,
  input  logic           scale_x2,
  input  logic           recov_same_en,
  input  logic           recov_diff_en,
  output logic [NCS-1:0] mem_cs_n,
  output logic           mem_av_n,
  output logic           mem_we_n,
  output logic           mem_oe_n,
  output logic [DW-1:0]  mem_dout,
  output logic           mem_dout_en,
  input  logic [DW-1:0]  mem_din
);

  function automatic logic [CW-1:0] sc(input logic x2, input logic [TW-1:0] v);
    return x2 ? {v, 1'b0} : {1'b0, v};
  endfunction

  logic           busy, wr_q, done_q, have_prev;
  logic [CSW-1:0] cs_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic [CW-1:0]  cnt, idle_cnt, tot, turn_s, recov_s, need;
  logic [CW:0]    cnt_nx;
  logic           last, recov_hit, accept;
  logic [3:0]     raw, late, hsel, eff;

  assign tot     = sc(scale_x2, wr_q ? t_wr_cycle : t_rd_cycle);
  assign cnt_nx  = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  assign last    = busy && (cnt_nx >= {1'b0, tot});

  assign turn_s    = sc(scale_x2, t_turn);
  assign recov_hit = (req_cs == cs_q) ? recov_same_en : recov_diff_en;
  assign recov_s   = recov_hit ? sc(scale_x2, t_recov) : '0;
  assign need      = (turn_s > recov_s) ? turn_s : recov_s;
  assign req_ready = !busy && (!have_prev || idle_cnt >= need);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wr_q      <= 1'b0;
      cs_q      <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      cnt       <= '0;
      idle_cnt  <= '0;
      done_q    <= 1'b0;
      have_prev <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy      <= 1'b1;
        wr_q      <= req_write;
        cs_q      <= req_cs;
        wdata_q   <= req_wdata;
        cnt       <= '0;
        have_prev <= 1'b1;
      end else if (busy) begin
        cnt <= cnt_nx[CW-1:0];
        if (last) begin
          busy     <= 1'b0;
          idle_cnt <= '0;
        end
      end else if (idle_cnt != '1) begin
        idle_cnt <= idle_cnt + {{(CW-1){1'b0}}, 1'b1};
      end
      if (busy && !wr_q && cnt == sc(scale_x2, t_access))
        rdata_q <= mem_din;
    end
  end

  function automatic logic win(input logic b, input logic [CW-1:0] c,
                               input logic [CW-1:0] on, input logic [CW-1:0] off);
    return b && (c >= on) && (c < off);
  endfunction

  assign raw[0] = win(busy, cnt, sc(scale_x2, t_cs_on),
                      sc(scale_x2, wr_q ? t_cs_wr_off : t_cs_rd_off));
  assign raw[1] = win(busy, cnt, sc(scale_x2, t_av_on),
                      sc(scale_x2, wr_q ? t_av_wr_off : t_av_rd_off));
  assign raw[2] = wr_q && win(busy, cnt, sc(scale_x2, t_we_on), sc(scale_x2, t_we_off));
  assign raw[3] = !wr_q && win(busy, cnt, sc(scale_x2, t_oe_on), sc(scale_x2, t_oe_off));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) late <= '0;
    else        late <= raw;
  end

  assign hsel = {late_oe, late_we, late_av, late_cs};
  assign eff  = (hsel & late) | (~hsel & raw);

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign mem_cs_n[i] = ~(eff[0] && (cs_q == CSW'(i)));
  end

  assign mem_av_n    = ~eff[1];
  assign mem_we_n    = ~eff[2];
  assign mem_oe_n    = ~eff[3];
  assign mem_dout    = wdata_q;
  assign mem_dout_en = busy && wr_q;
  assign rsp_done    = done_q;
  assign rsp_rdata   = rdata_q;

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&mem_cs_n && mem_av_n && mem_we_n && mem_oe_n)); // R1
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R2
  AST_WE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dout_en); // R4
  AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_en); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !busy); // R5
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R12

endmodule

// File: tb/tb_amem_strobe_seq.sv
module tb_amem_strobe_seq;
  localparam int CLK_PERIOD = 20;
  localparam int NCS = 4, TW = 5, DW = 16, CSW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_write = 0, rsp_done, mem_av_n, mem_we_n, mem_oe_n, mem_dout_en;
  logic [CSW-1:0] req_cs = '0;
  logic [DW-1:0] req_wdata = '0, rsp_rdata, mem_dout, mem_din = '0;
  logic [NCS-1:0] mem_cs_n;
  logic [TW-1:0] t_cs_on, t_cs_rd_off, t_cs_wr_off, t_av_on, t_av_rd_off, t_av_wr_off;
  logic [TW-1:0] t_we_on, t_we_off, t_oe_on, t_oe_off, t_access, t_rd_cycle, t_wr_cycle, t_turn, t_recov;
  logic late_cs = 0, late_av = 0, late_we = 0, late_oe = 0, scale_x2 = 0, recov_same_en = 0, recov_diff_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amem_strobe_seq #(.NCS(NCS), .TW(TW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .t_cs_on(t_cs_on), .t_cs_rd_off(t_cs_rd_off), .t_cs_wr_off(t_cs_wr_off),
    .t_av_on(t_av_on), .t_av_rd_off(t_av_rd_off), .t_av_wr_off(t_av_wr_off),
    .t_we_on(t_we_on), .t_we_off(t_we_off), .t_oe_on(t_oe_on), .t_oe_off(t_oe_off),
    .t_access(t_access), .t_rd_cycle(t_rd_cycle), .t_wr_cycle(t_wr_cycle),
    .t_turn(t_turn), .t_recov(t_recov), .late_cs(late_cs), .late_av(late_av),
    .late_we(late_we), .late_oe(late_oe), .scale_x2(scale_x2),
    .recov_same_en(recov_same_en), .recov_diff_en(recov_diff_en),
    .mem_cs_n(mem_cs_n), .mem_av_n(mem_av_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din));

  int checks = 0, fails = 0, last_cs = -1;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_rd = '0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sv(input logic [TW-1:0] v);
    return scale_x2 ? 2 * int'(v) : int'(v);
  endfunction

  function automatic bit rawk(input int k, input int on, input int off, input int tot);
    return (k >= 0) && (k < tot) && (k >= on) && (k < off);
  endfunction

  function automatic bit want(input bit lt, input bit first, input int k, input int on, input int off, input int tot);
    return (lt && first) ? rawk(k - 1, on, off, tot) : rawk(k, on, off, tot);
  endfunction

  // monitor: pops the expected read data at every done pulse (R5, R6)
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && rsp_done) begin
      if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected done", 1, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R6", "read data", rsp_rdata, e);
      end
    end
  end

  task automatic run_access(input bit wr, input int cs, input logic [DW-1:0] val, input string tag);
    int tot, con, coff, aon, aoff, won, woff, oon, ooff;
    int e_cs = 0, e_av = 0, e_we = 0, e_oe = 0, e_done = 0, e_dout = 0;
    logic [NCS-1:0] ecs;
    bit w;
    tot = sv(wr ? t_wr_cycle : t_rd_cycle);
    if (tot < 1) tot = 1;
    con = sv(t_cs_on);  coff = sv(wr ? t_cs_wr_off : t_cs_rd_off);
    aon = sv(t_av_on);  aoff = sv(wr ? t_av_wr_off : t_av_rd_off);
    won = sv(t_we_on);  woff = sv(t_we_off);
    oon = sv(t_oe_on);  ooff = sv(t_oe_off);
    if (!wr) last_rd = val + DW'(sv(t_access));
    exp_q.push_back(last_rd);
    req_write = wr; req_cs = CSW'(cs); req_wdata = val; req_valid = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= tot; k++) begin
      for (int ph = 0; ph < 2; ph++) begin
        #(CLK_PERIOD/4);
        if (ph == 0) begin
          if (k == 0) req_valid = 1'b0;
          mem_din = val + DW'(k);
          e_done += (rsp_done !== (k == tot));
          if (k < tot && wr) e_dout += (mem_dout !== val || mem_dout_en !== 1'b1);
          if (k == tot) e_dout += (mem_dout_en !== 1'b0);
        end
        w = want(late_cs, ph == 0, k, con, coff, tot);
        ecs = w ? ~(NCS'(1) << cs) : '1;
        e_cs += (mem_cs_n !== ecs);
        e_av += (mem_av_n !== !want(late_av, ph == 0, k, aon, aoff, tot));
        e_we += (mem_we_n !== !(wr && want(late_we, ph == 0, k, won, woff, tot)));
        e_oe += (mem_oe_n !== !(!wr && want(late_oe, ph == 0, k, oon, ooff, tot)));
        if (!(ph == 1 && k == tot)) #(CLK_PERIOD/4);
      end
    end
    chk(e_cs == 0, {tag, " R2"}, "chip-select half-cycle mismatches", e_cs, 0);
    chk(e_av == 0, {tag, " R3"}, "address-valid mismatches", e_av, 0);
    chk(e_we == 0 && e_oe == 0, {tag, " R4"}, "we/oe mismatches", e_we + e_oe, 0);
    chk(e_done == 0, {tag, " R5"}, "done timing mismatches", e_done, 0);
    chk(e_dout == 0, {tag, " R6"}, "write data drive mismatches", e_dout, 0);
    last_cs = cs;
  endtask

  // called at 3/4 of the done cycle
  task automatic check_gap(input int ncs, input bit nwr, input string tag);
    int need, rc, n = 0, bad = 0;
    need = sv(t_turn);
    rc = ((ncs == last_cs) ? recov_same_en : recov_diff_en) ? sv(t_recov) : 0;
    if (rc > need) need = rc;
    req_cs = CSW'(ncs); req_write = nwr; req_valid = 1'b1;
    #1;
    while (req_ready !== 1'b1 && n < 200) begin
      n++;
      bad += (mem_cs_n !== '1 || mem_av_n !== 1'b1 || mem_we_n !== 1'b1 || mem_oe_n !== 1'b1);
      #(CLK_PERIOD);
    end
    chk(n == need, tag, "ready-low cycles after done", n, need);
    chk(bad == 0, "R12", "strobes while request refused", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_cs_on = 1; t_cs_rd_off = 7; t_cs_wr_off = 8;
    t_av_on = 0; t_av_rd_off = 2; t_av_wr_off = 3;
    t_we_on = 2; t_we_off = 7; t_oe_on = 3; t_oe_off = 7;
    t_access = 5; t_rd_cycle = 8; t_wr_cycle = 9; t_turn = 0; t_recov = 3;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4) rst_n = 1'b1;
    @(posedge clk);
    #(3*CLK_PERIOD/4);
    chk(mem_cs_n === '1 && mem_av_n === 1'b1 && mem_we_n === 1'b1 && mem_oe_n === 1'b1,
        "R1", "strobes after reset", {mem_cs_n, mem_av_n, mem_we_n, mem_oe_n}, 7'h7f);
    chk(req_ready === 1'b1 && rsp_done === 1'b0, "R1", "ready/done after reset", {req_ready, rsp_done}, 2'b10);

    run_access(0, 0, 16'h1000, "base");
    check_gap(1, 1, "R9");
    run_access(1, 1, 16'h2000, "base");
    t_turn = 2;
    check_gap(1, 0, "R9");
    run_access(0, 1, 16'h3000, "base");
    t_turn = 0; recov_same_en = 1; t_recov = 3;
    check_gap(1, 0, "R10");
    t_cs_rd_off = 12;
    run_access(0, 1, 16'h4000, "R5");
    check_gap(2, 1, "R10");
    run_access(1, 2, 16'h5000, "base");
    recov_diff_en = 1; t_recov = 4; t_turn = 2;
    check_gap(3, 0, "R11");
    late_cs = 1; late_av = 1; late_we = 1; late_oe = 1; t_cs_rd_off = 7;
    run_access(0, 3, 16'h6000, "R7");
    t_turn = 0; recov_same_en = 0; recov_diff_en = 0;
    check_gap(0, 1, "R9");
    scale_x2 = 1;
    run_access(1, 0, 16'h7000, "R7 R8");
    t_turn = 1;
    check_gap(2, 0, "R8");
    late_cs = 0; late_av = 0; late_we = 0; late_oe = 0; t_cs_rd_off = 12;
    run_access(0, 2, 16'h8000, "R8");
    req_valid = 1'b0;
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R5", "outstanding done pulses", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule